// File: doc/BRIEF.md
# Priority Bus Request Arbiter

This block decides, cycle by cycle, whether the symmetric agent on a shared two-agent system bus may place new requests into its request queue. A second, high-priority agent can claim the bus. To do so it drives an active-low priority line, and the block generates that line from three inputs from the priority agent: its pending-work flag, its issue strobe and its completion strobe. The block counts the priority agent's outstanding transactions. It holds the priority line asserted until the count is back at zero and no new work is pending.

The symmetric agent sees a registered issue-enable. When priority is asserted, the issue-enable drops and the symmetric agent stops issuing. The one exception is a locked sequence that the symmetric agent has already started. The lock state begins with the first accepted locked request and ends with the accepted final request of that sequence. While the lock state holds, the issue-enable stays high even under priority. The block also registers the symmetric agent's active-low bus request line. All inputs are sampled on the common bus clock.

Top module: `prio_bus_arbiter`

## Requirements
- R1: Reset has these effects: `prio_n` and `br_n` go high (deasserted), `hp_count` goes to 0, `lock_active` goes to 0 and `issue_en` goes to 1.
- R2: If `hp_work` is high at a clock edge, `prio_n` is low after that edge.
- R3: `prio_n` stays low at every edge where `hp_count` was nonzero just before the edge. It returns high on the edge after the count reaches zero, provided `hp_work` is low on that edge.
- R4: On each edge, `hp_issue` adds one to `hp_count` and `hp_done` subtracts one. When both are high, the count does not change. A completion that arrives when the count is zero and `hp_issue` is low is ignored.
- R5: `hp_count` saturates at 2^CNT_W-1. An issue that arrives at that value without a completion leaves the count unchanged.
- R6: `issue_en` goes low on the same edge at which `prio_n` goes low, unless `lock_active` is set after that edge. It goes high again on the edge at which `prio_n` returns high.
- R7: A symmetric request is accepted when `sym_issue` is high while `issue_en` is high. An accepted request with `sym_lock` set makes `lock_active` high. An accepted request with `sym_last` set clears `lock_active`, and `sym_last` wins when both flags are set.
- R8: While `lock_active` is high, `issue_en` stays high whatever the priority line does. If priority is still asserted when the lock clears, `issue_en` drops on the edge at which the lock clears.
- R9: A `sym_issue` that arrives while `issue_en` is low is ignored. In particular it does not set `lock_active`.
- R10: `br_n` is the symmetric request input `sym_req_n`, registered once.
- R11: No request is ever accepted while `prio_n` is low and `lock_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_req_n | input | 1 | Symmetric agent bus request, active low |
| sym_issue | input | 1 | Symmetric agent issues a request this cycle |
| sym_lock | input | 1 | Issued request belongs to a locked sequence |
| sym_last | input | 1 | Issued request is the final one of the locked sequence |
| hp_work | input | 1 | Priority agent has pending work |
| hp_issue | input | 1 | Priority agent issues a request this cycle |
| hp_done | input | 1 | One priority request completes this cycle |
| prio_n | output | 1 | Priority line, active low |
| br_n | output | 1 | Registered symmetric bus request line, active low |
| issue_en | output | 1 | Symmetric agent may issue new requests |
| lock_active | output | 1 | Locked sequence in progress |
| hp_count | output | CNT_W | Outstanding priority requests |

## Verification
The bench goes after several corner cases, and each one catches a specific kind of fault.

- **Priority arriving in the middle of a lock.** A design that honours priority too early drops `issue_en` before the final locked request, which breaks the atomic sequence.
- **Release timing.** The bench checks the edge after the outstanding count falls to zero. A design that releases one cycle early hands back the bus while priority traffic is still in flight. A design that releases late stalls the symmetric agent for no reason.
- **Counter corners.** The bench applies simultaneous issue and completion, completion at zero, and issue at the maximum count. A wrong counter shows up as a count that wraps or underflows, and the priority line then either sticks low or releases in the middle of a burst.
- **Issue attempts while `issue_en` is low.** A design that accepts them can latch a false lock and then keep `issue_en` high through the next priority phase.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_e;

endpackage

// File: rtl/arb_hp_track.sv
module arb_hp_track #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hp_work,
    input  logic             hp_issue,
    input  logic             hp_done,
    output logic             prio_next,
    output logic             prio_n,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             prio_act;
    } hp_st_t;

    hp_st_t st_d, st_q;
    logic   inc, dec;

    always_comb begin
        st_d = st_q;
        inc  = hp_issue && ((st_q.count != CNT_MAX) || hp_done);
        dec  = hp_done  && ((st_q.count != CNT_ZERO) || hp_issue);
        if (inc && !dec) begin
            st_d.count = st_q.count + 1'b1;
        end else if (dec && !inc) begin
            st_d.count = st_q.count - 1'b1;
        end
        st_d.prio_act = hp_work || (st_q.count != CNT_ZERO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prio_next = st_d.prio_act;
    assign prio_n    = !st_q.prio_act;
    assign count     = st_q.count;

    // R3
    cnt_holds_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count != CNT_ZERO) |=> !prio_n);

    // R3
    release_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prio_n) |-> ($past(st_q.count) == CNT_ZERO && !$past(hp_work)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CNT_MAX && hp_issue && !hp_done) |=> (st_q.count == CNT_MAX));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CNT_ZERO && hp_done && !hp_issue) |=> (st_q.count == CNT_ZERO));

endmodule

// File: rtl/arb_lock_track.sv
module arb_lock_track
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic sym_lock,
    input  logic sym_last,
    output logic lock_next,
    output logic lock_q
);
    lock_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept && sym_last) begin
            st_d = LK_FREE;
        end else if (accept && sym_lock) begin
            st_d = LK_HELD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LK_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_next = (st_d == LK_HELD);
    assign lock_q    = (st_q == LK_HELD);

    // R9
    lock_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !accept) |=> !lock_q);

    // R7
    last_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sym_last) |=> !lock_q);

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_req_n,
    input  logic             sym_issue,
    input  logic             sym_lock,
    input  logic             sym_last,
    input  logic             hp_work,
    input  logic             hp_issue,
    input  logic             hp_done,
    output logic             prio_n,
    output logic             br_n,
    output logic             issue_en,
    output logic             lock_active,
    output logic [CNT_W-1:0] hp_count
);
    typedef struct packed {
        logic issue_en;
        logic br_n;
    } gate_st_t;

    gate_st_t gt_d, gt_q;
    logic     prio_next;
    logic     lock_next;
    logic     accept;

    assign accept = sym_issue && gt_q.issue_en;

    arb_hp_track #(.CNT_W(CNT_W)) i_hp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hp_work   (hp_work),
        .hp_issue  (hp_issue),
        .hp_done   (hp_done),
        .prio_next (prio_next),
        .prio_n    (prio_n),
        .count     (hp_count)
    );

    arb_lock_track i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sym_lock  (sym_lock),
        .sym_last  (sym_last),
        .lock_next (lock_next),
        .lock_q    (lock_active)
    );

    always_comb begin
        gt_d          = gt_q;
        gt_d.issue_en = !prio_next || lock_next;
        gt_d.br_n     = sym_req_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gt_q <= '{issue_en: 1'b1, br_n: 1'b1};
        end else begin
            gt_q <= gt_d;
        end
    end

    assign issue_en = gt_q.issue_en;
    assign br_n     = gt_q.br_n;

    // R11
    no_unlocked_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio_n && sym_issue && issue_en) |-> lock_active);

    // R8
    lock_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |-> issue_en);

    // R6
    idle_bus_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_n |-> issue_en);

    // R10
    br_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_n == $past(sym_req_n));

endmodule

// File: tb/test_prio_bus_arbiter.sv
module test_prio_bus_arbiter;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_req_n = 1'b1, sym_issue = 1'b0, sym_lock = 1'b0, sym_last = 1'b0;
    logic hp_work = 1'b0, hp_issue = 1'b0, hp_done = 1'b0;
    logic prio_n, br_n, issue_en, lock_active;
    logic [CNT_W-1:0] hp_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    int m_cnt;
    bit m_prio, m_lock, m_ien, m_br_n;

    always #10 clk = ~clk;

    prio_bus_arbiter #(.CNT_W(CNT_W)) i_prio_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .sym_req_n(sym_req_n), .sym_issue(sym_issue),
        .sym_lock(sym_lock), .sym_last(sym_last), .hp_work(hp_work),
        .hp_issue(hp_issue), .hp_done(hp_done), .prio_n(prio_n), .br_n(br_n),
        .issue_en(issue_en), .lock_active(lock_active), .hp_count(hp_count)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R2"},  "prio_n",      int'(prio_n),      int'(!m_prio));
        chk({tag, " R4"},  "hp_count",    int'(hp_count),    m_cnt);
        chk({tag, " R6"},  "issue_en",    int'(issue_en),    int'(m_ien));
        chk({tag, " R7"},  "lock_active", int'(lock_active), int'(m_lock));
        chk({tag, " R10"}, "br_n",        int'(br_n),        int'(m_br_n));
    endtask

    // one bus cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit rq_n, input bit iss, input bit lk, input bit lst,
                       input bit wk, input bit hi, input bit hd, input string tag);
        bit acc, inc, dec;
        sym_req_n = rq_n; sym_issue = iss; sym_lock = lk; sym_last = lst;
        hp_work = wk; hp_issue = hi; hp_done = hd;
        #1;
        // R11 invariant, seen at the ports
        if (iss && issue_en && !prio_n && !lock_active) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 unlocked accept under priority actual=1 expected=0");
        end
        @(posedge clk);
        acc = iss && m_ien;
        inc = hi && (m_cnt != CMAX || hd);
        dec = hd && (m_cnt != 0 || hi);
        m_prio = wk || (m_cnt != 0);
        if (inc && !dec) m_cnt++;
        else if (dec && !inc) m_cnt--;
        if (acc && lst) m_lock = 0;
        else if (acc && lk) m_lock = 1;
        m_ien = !m_prio || m_lock;
        m_br_n = rq_n;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #3_000_000;
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_cnt = 0; m_prio = 0; m_lock = 0; m_ien = 1; m_br_n = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        compare_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after release");

        // R10 request line follows, R6 enable high while idle
        cyc(0, 1, 0, 0, 0, 0, 0, "R10 req");
        cyc(0, 1, 0, 0, 0, 0, 0, "R10 req");
        cyc(1, 0, 0, 0, 0, 0, 0, "R10 drop");

        // R2 R3 priority burst of three requests
        cyc(1, 0, 0, 0, 1, 0, 0, "R2 assert");
        cyc(1, 0, 0, 0, 1, 1, 0, "R4 issue");
        cyc(1, 1, 0, 0, 1, 1, 0, "R9 blocked");
        cyc(1, 0, 0, 0, 0, 1, 0, "R4 issue");
        cyc(1, 0, 0, 0, 0, 0, 1, "R3 done");
        cyc(1, 0, 0, 0, 0, 1, 1, "R4 both");
        cyc(1, 0, 0, 0, 0, 0, 1, "R3 done");
        cyc(1, 0, 0, 0, 0, 0, 1, "R3 last done");
        cyc(1, 0, 0, 0, 0, 0, 0, "R3 release");
        cyc(1, 0, 0, 0, 0, 0, 1, "R4 done at zero");
        cyc(1, 0, 0, 0, 0, 1, 1, "R4 both at zero");
        idle(2, "R6 idle");

        // R5 saturation
        for (int i = 0; i < CMAX + 3; i++) cyc(1, 0, 0, 0, 1, 1, 0, "R5 fill");
        cyc(1, 0, 0, 0, 0, 1, 1, "R5 both at max");
        for (int i = 0; i < CMAX; i++) cyc(1, 0, 0, 0, 0, 0, 1, "R5 drain");
        idle(2, "R3 release");

        // R7 R8 lock started, then priority arrives
        cyc(0, 1, 1, 0, 0, 0, 0, "R7 lock start");
        cyc(0, 0, 0, 0, 1, 0, 0, "R8 prio in lock");
        cyc(0, 1, 1, 0, 1, 1, 0, "R8 locked issue");
        cyc(0, 0, 0, 0, 1, 0, 0, "R8 hold");
        cyc(0, 1, 1, 1, 1, 0, 0, "R8 last clears");
        cyc(0, 1, 1, 0, 1, 0, 0, "R9 lock attempt blocked");
        cyc(0, 1, 0, 0, 0, 0, 1, "R9 still blocked");
        cyc(1, 0, 0, 0, 0, 0, 0, "R3 release");
        idle(2, "R6 back");

        // R7 last flag wins over lock flag, no lock held
        cyc(1, 1, 1, 1, 0, 0, 0, "R7 both flags");
        cyc(1, 1, 0, 1, 0, 0, 0, "R7 stray last");

        // R11 mixed traffic
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom;
            cyc(bit'(r[0]), bit'(r[1]), bit'(r[2] & r[3]), bit'(r[4] & r[5] & r[6]),
                bit'(r[7] & r[8]), bit'(r[9]), bit'(r[10] & (r[11] | r[12])), "R11 mix");
        end
        idle(CMAX + 4, "R3 drain");

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule